// File: doc/BRIEF.md
# Palette DAC Hidden Command Register Front End

This block is the register front end of a palette DAC. The host reaches it through a 2-bit register select, separate read and write strobes and an 8-bit data path. Select 2 is the pixel-mask register. A run of back-to-back reads of that register unlocks a hidden command register. The block counts those reads. Depending on the count, a read returns the mask, an identification byte or the command register. A write to select 2 that lands at the unlocked count loads the command register instead of the mask.

The upper nibble of the command register selects the pixel format. The block decodes it into a registered bits-per-pixel value: 8, 15, 16, 24 or 32. The static `VARIANT` parameter picks one of three decode tables. Variant 0 is the generic part. It is also the only variant that returns an ID byte during the unlock sequence. Selects 0, 1 and 3 are plain byte registers that stand in for the normal palette register path.

Top module: `dac_hidden_cmd`

## Requirements
- R1: After reset the unlock count is 0, the command register is 0x00, the mask register is 0xFF, the plain registers at selects 0, 1 and 3 read 0x00, and `depth_o` is 8.
- R2: Each read with `sel_i`=2 advances the unlock count by one. A read that leaves the count at 1, 2 or 3 returns the mask register.
- R3: The fourth consecutive mask read returns 0x70 when `VARIANT`=0. For `VARIANT`=1 or 2 it returns the mask register.
- R4: The fifth consecutive mask read returns the command register and returns the count to 0, so the sixth read counts as the first.
- R5: A write with `sel_i`=2 while the count is 4 loads the command register and leaves the mask unchanged. Any other write with `sel_i`=2 loads the mask and leaves the command register unchanged. Every write with `sel_i`=2 returns the count to 0.
- R6: Any read or write with `sel_i` equal to 0, 1 or 3 returns the count to 0. A write to one of these selects stores the byte, and a read of that select returns it.
- R7: `rdata_o` is 0x00 in any cycle without a read. When `rd_i` and `wr_i` are high together, the access acts as a write only.
- R8: On all variants, command nibbles 0x0 and 0x1 give 8, nibbles 0x2, 0x3 and 0x8 give 15, nibbles 0x4 and 0x9 give 24, nibble 0x5 gives 16, and nibbles 0xB, 0xD and 0xF give 8.
- R9: With `VARIANT`=1, nibble 0xA gives 15, 0xC gives 15, 0xE gives 16, 0x6 gives 24 and 0x7 gives 24.
- R10: With `VARIANT`=2, nibble 0xA gives 16, 0xC gives 16, 0xE gives 24, 0x6 gives 16 and 0x7 gives 32. With `VARIANT`=0 these nibbles give 15, 16, 24, 16 and 32.
- R11: `depth_o` follows the command register with one clock of delay. A command write taken at clock edge k changes `depth_o` at edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 2 | Register select; 2 is the pixel-mask register |
| rd_i | input | 1 | Read strobe, one access per high cycle |
| wr_i | input | 1 | Write strobe, one access per high cycle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the cycle `rd_i` is high |
| depth_o | output | 6 | Decoded bits per pixel |

## Verification
The bench drives an unlock run of exactly five reads. A design that does not wrap after the fifth read would return the command register again on the sixth. The bench breaks a run with an access to another select and checks that the count starts over. A design that only resets on reads of other selects would then unlock early. It also writes the mask at counts 0 through 3 and then at count 4. An off-by-one unlock would corrupt the command register or the mask. Every nibble is loaded into three instances of different variants at once, and `depth_o` is checked on the edge where it must still hold the old value as well as on the edge where it changes. A decode that is one clock off, or a table swapped between variants, shows up as a wrong depth.

// File: rtl/dac_hcr_pkg.sv
package dac_hcr_pkg;
  typedef enum logic [1:0] {
    SEL_WIDX = 2'd0,
    SEL_DATA = 2'd1,
    SEL_MASK = 2'd2,
    SEL_RIDX = 2'd3
  } dac_sel_e;

  // mode nibble -> bits per pixel, per variant
  function automatic logic [5:0] mode_depth(input int unsigned variant, input logic [3:0] nib);
    logic [5:0] d;
    case (nib)
      4'h0, 4'h1:       d = 6'd8;
      4'h2, 4'h3, 4'h8: d = 6'd15;
      4'h4, 4'h9:       d = 6'd24;
      4'h5:             d = 6'd16;
      4'hA:             d = (variant == 2) ? 6'd16 : 6'd15;
      4'hC:             d = (variant == 1) ? 6'd15 : 6'd16;
      4'hE:             d = (variant == 1) ? 6'd16 : 6'd24;
      4'h6:             d = (variant == 1) ? 6'd24 : 6'd16;
      4'h7:             d = (variant == 1) ? 6'd24 : 6'd32;
      default:          d = 6'd8;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/dac_unlock_seq.sv
module dac_unlock_seq #(
  parameter int unsigned UNLOCK_LEN = 4,
  localparam int unsigned CW = $clog2(UNLOCK_LEN + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mask_rd_i,
  input  logic          mask_wr_i,
  input  logic          other_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] CNT_OPEN = CW'(UNLOCK_LEN);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (other_i || mask_wr_i) cnt_d = '0;
    else if (mask_rd_i)       cnt_d = (cnt_q == CNT_OPEN) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  a_r4_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_OPEN);
  a_r4_open_read_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_rd_i && !mask_wr_i && !other_i && cnt_q == CNT_OPEN) |=> cnt_q == '0);
  a_r6_other_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    other_i |=> cnt_q == '0);
  a_r2_read_advances: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_rd_i && !mask_wr_i && !other_i && cnt_q < CNT_OPEN) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/dac_depth_decode.sv
module dac_depth_decode
  import dac_hcr_pkg::*;
#(
  parameter int unsigned VARIANT = 0,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] cmd_i,
  output logic [5:0]    depth_o
);
  logic [5:0] depth_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) depth_q <= 6'd8;
    else         depth_q <= mode_depth(VARIANT, cmd_i[DW-1 -: 4]);
  end

  assign depth_o = depth_q;

  a_r8_depth_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_q inside {6'd8, 6'd15, 6'd16, 6'd24, 6'd32});
  a_r11_depth_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(cmd_i) |=> $stable(depth_q));
endmodule

// File: rtl/dac_hidden_cmd.sv
module dac_hidden_cmd
  import dac_hcr_pkg::*;
#(
  parameter int unsigned VARIANT    = 0,
  parameter int unsigned DW         = 8,
  parameter int unsigned UNLOCK_LEN = 4,
  parameter logic [7:0]  ID_BYTE    = 8'h70
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    sel_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [5:0]    depth_o
);
  localparam int unsigned CW   = $clog2(UNLOCK_LEN + 2);
  localparam int unsigned NSEL = 4;
  localparam logic [CW-1:0] CNT_OPEN = CW'(UNLOCK_LEN);
  localparam logic [CW-1:0] CNT_ID   = CW'(UNLOCK_LEN - 1);

  logic          is_mask, do_wr, do_rd;
  logic          mask_rd, mask_wr, other_acc;
  logic [CW-1:0] cnt;
  logic [DW-1:0] mask_q, cmd_q;
  logic [DW-1:0] plain_q [NSEL];

  assign is_mask   = (sel_i == SEL_MASK);
  assign do_wr     = wr_i;
  assign do_rd     = rd_i && !wr_i;  // write wins a collision
  assign mask_rd   = do_rd && is_mask;
  assign mask_wr   = do_wr && is_mask;
  assign other_acc = (do_rd || do_wr) && !is_mask;

  dac_unlock_seq #(.UNLOCK_LEN(UNLOCK_LEN)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mask_rd_i (mask_rd),
    .mask_wr_i (mask_wr),
    .other_i   (other_acc),
    .cnt_o     (cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      cmd_q  <= '0;
    end else if (mask_wr) begin
      if (cnt == CNT_OPEN) cmd_q  <= wdata_i;
      else                 mask_q <= wdata_i;
    end
  end

  for (genvar s = 0; s < NSEL; s++) begin : g_plain
    if (s == int'(SEL_MASK)) begin : g_hole
      assign plain_q[s] = '0;
    end else begin : g_reg
      logic [DW-1:0] r_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                             r_q <= '0;
        else if (do_wr && sel_i == 2'(s))        r_q <= wdata_i;
      end
      assign plain_q[s] = r_q;
    end
  end

  logic [DW-1:0] mask_view;
  if (VARIANT == 0) begin : g_id
    assign mask_view = (cnt == CNT_ID) ? DW'(ID_BYTE) : mask_q;
  end else begin : g_noid
    assign mask_view = mask_q;
  end

  always_comb begin
    rdata_o = '0;
    if (do_rd) begin
      if (!is_mask)             rdata_o = plain_q[sel_i];
      else if (cnt == CNT_OPEN) rdata_o = cmd_q;
      else                      rdata_o = mask_view;
    end
  end

  dac_depth_decode #(.VARIANT(VARIANT), .DW(DW)) u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_i   (cmd_q),
    .depth_o (depth_o)
  );

  a_r5_cmd_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cmd_q) |-> $past(wr_i && sel_i == SEL_MASK && cnt == CNT_OPEN));
  a_r5_mask_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mask_q) |-> $past(wr_i && sel_i == SEL_MASK && cnt != CNT_OPEN));
  a_r5_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == SEL_MASK) |=> cnt == '0);
  a_r7_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == '0);
endmodule

// File: tb/sim_dac_hidden_cmd.sv
module sim_dac_hidden_cmd;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel = '0;
  logic       rd = 1'b0, wr = 1'b0;
  logic [7:0] wd = '0;
  logic [7:0] rdo [3];
  logic [5:0] dep [3];

  int checks = 0, errors = 0;

  // bench model
  int         m_cnt;
  logic [7:0] m_mask, m_cmd;
  logic [7:0] m_plain [4];
  logic [5:0] m_dep [3];

  always #2 clk = ~clk;

  dac_hidden_cmd #(.VARIANT(0)) u0 (.clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .rd_i(rd), .wr_i(wr),
    .wdata_i(wd), .rdata_o(rdo[0]), .depth_o(dep[0]));
  dac_hidden_cmd #(.VARIANT(1)) u1 (.clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .rd_i(rd), .wr_i(wr),
    .wdata_i(wd), .rdata_o(rdo[1]), .depth_o(dep[1]));
  dac_hidden_cmd #(.VARIANT(2)) u2 (.clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .rd_i(rd), .wr_i(wr),
    .wdata_i(wd), .rdata_o(rdo[2]), .depth_o(dep[2]));

  function automatic logic [5:0] exp_depth(input int v, input logic [3:0] n);
    if (n == 4'h0 || n == 4'h1 || n == 4'hB || n == 4'hD || n == 4'hF) return 6'd8;  // R8
    if (n == 4'h2 || n == 4'h3 || n == 4'h8) return 6'd15;
    if (n == 4'h4 || n == 4'h9) return 6'd24;
    if (n == 4'h5) return 6'd16;
    if (v == 1) begin  // R9
      case (n)
        4'hA: return 6'd15; 4'hC: return 6'd15; 4'hE: return 6'd16;
        4'h6: return 6'd24; default: return 6'd24;
      endcase
    end
    if (v == 2) begin  // R10
      case (n)
        4'hA: return 6'd16; 4'hC: return 6'd16; 4'hE: return 6'd24;
        4'h6: return 6'd16; default: return 6'd32;
      endcase
    end
    case (n)  // R10 generic
      4'hA: return 6'd15; 4'hC: return 6'd16; 4'hE: return 6'd24;
      4'h6: return 6'd16; default: return 6'd32;
    endcase
  endfunction

  function automatic logic [7:0] exp_read(input int v);
    if (!rd || wr) return 8'h00;                      // R7
    if (sel != 2'd2) return m_plain[sel];             // R6
    if (m_cnt == 4) return m_cmd;                     // R4
    if (m_cnt == 3) return (v == 0) ? 8'h70 : m_mask; // R3
    return m_mask;                                    // R2
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] s, input logic r, input logic w, input logic [7:0] d);
    @(negedge clk);
    sel = s; rd = r; wr = w; wd = d;
    #1;
    for (int v = 0; v < 3; v++) chk("R2/R3/R4/R6/R7 rdata", rdo[v], exp_read(v));
    @(posedge clk);
    #1;
    for (int v = 0; v < 3; v++) m_dep[v] = exp_depth(v, m_cmd[7:4]);  // R11 one-clock lag
    if (w) begin
      if (s == 2'd2) begin
        if (m_cnt == 4) m_cmd = d; else m_mask = d;  // R5
      end else m_plain[s] = d;
      m_cnt = 0;
    end else if (r) begin
      if (s == 2'd2) m_cnt = (m_cnt == 4) ? 0 : m_cnt + 1;
      else m_cnt = 0;
    end
    for (int v = 0; v < 3; v++) chk("R8/R9/R10/R11 depth", {2'b0, dep[v]}, {2'b0, m_dep[v]});
    @(negedge clk);
    rd = 1'b0; wr = 1'b0;
  endtask

  task automatic unlock_write(input logic [7:0] d);
    for (int i = 0; i < 4; i++) access(2'd2, 1'b1, 1'b0, 8'h00);
    access(2'd2, 1'b0, 1'b1, d);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_cnt = 0; m_mask = 8'hFF; m_cmd = 8'h00;
    for (int i = 0; i < 4; i++) m_plain[i] = 8'h00;
    for (int v = 0; v < 3; v++) m_dep[v] = 6'd8;
    repeat (3) @(posedge clk);
    #1;
    for (int v = 0; v < 3; v++) chk("R1 reset depth", {2'b0, dep[v]}, 8'd8);
    rst_n = 1'b1;
    // R1 reset contents
    access(2'd0, 1'b1, 1'b0, 8'h00);
    access(2'd3, 1'b1, 1'b0, 8'h00);
    access(2'd2, 1'b1, 1'b0, 8'h00);  // R1 mask FF
    // R2..R4: six reads in a row, fifth returns cmd, sixth restarts
    for (int i = 0; i < 6; i++) access(2'd2, 1'b1, 1'b0, 8'h00);
    // R5: mask write at counts 0..3, then unlock write
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < k; i++) access(2'd2, 1'b1, 1'b0, 8'h00);
      access(2'd2, 1'b0, 1'b1, 8'h40 + 8'(k));
    end
    unlock_write(8'h5A);
    access(2'd2, 1'b1, 1'b0, 8'h00);  // mask still 0x43
    // R6: interrupt run with another select
    access(2'd2, 1'b1, 1'b0, 8'h00);
    access(2'd2, 1'b1, 1'b0, 8'h00);
    access(2'd1, 1'b0, 1'b1, 8'hC3);
    for (int i = 0; i < 5; i++) access(2'd2, 1'b1, 1'b0, 8'h00);
    access(2'd1, 1'b1, 1'b0, 8'h00);
    // R7: read and write together acts as write
    access(2'd3, 1'b1, 1'b1, 8'h99);
    access(2'd3, 1'b1, 1'b0, 8'h00);
    // R8..R11: every nibble, with idle cycles to see the lag
    for (int n = 0; n < 16; n++) begin
      unlock_write({4'(n), 4'h3});
      access(2'd0, 1'b0, 1'b0, 8'h00);
      access(2'd0, 1'b0, 1'b0, 8'h00);
      for (int i = 0; i < 5; i++) access(2'd2, 1'b1, 1'b0, 8'h00);
    end
    // random mix, fixed seed
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      logic [1:0]  s;
      r = $urandom % 100;
      s = ($urandom % 10 < 7) ? 2'd2 : 2'($urandom % 4);
      if (r < 60)      access(s, 1'b1, 1'b0, 8'h00);
      else if (r < 75) access(s, 1'b0, 1'b1, 8'($urandom));
      else if (r < 80) access(s, 1'b1, 1'b1, 8'($urandom));
      else if (r < 88) unlock_write(8'($urandom));
      else             access(s, 1'b0, 1'b0, 8'h00);
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule